// File: doc/BRIEF.md
# QDR burst-of-two SRAM model

A synthesizable behavioural model of a small quad-data-rate SRAM. Reads and writes have their own data paths and share one address bus. Each address holds a pair of words that always move together as a burst of two. The double-rate transfers are folded onto a single clock. The shared address bus is split into its rising-half value, which carries the read address, and its falling-half value, which carries the write address. Each data pair travels as a "first" word and a "second" word in the same clock cycle.

A read is requested by driving `rd_req_n` low. Its pair appears one cycle after the next edge, marked by `q_valid`. A write is requested by driving `wr_req_n` low. Its data pair and its per-byte enables follow in the next cycle. The write is held in an internal pending stage before it lands in the array. Reads compare their address with every write that has not yet been committed and merge the pending bytes, newest last, so a read always returns the most recent data. This includes a write requested in the same cycle as the read.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset `q_valid` is 0, `q_first` and `q_second` are 0, and every address of the array reads back as zero.
- R2: When `rd_req_n` is low at edge N, `a_rise` is taken as the read address, and after edge N+1 `q_valid` is 1 with the stored pair on `q_first` and `q_second`.
- R3: When `wr_req_n` is low at edge N, `a_fall` is taken as the write address. The words `d_first` and `d_second`, with enables `bw_first_n` and `bw_second_n`, are taken at edge N+1, and later reads of that address return them.
- R4: Enable bit i (active low) of `bw_first_n` or `bw_second_n` writes bits [9i+8:9i] of the matching word. A high bit leaves those bits of the stored word unchanged.
- R5: A read and a write requested in the same cycle both proceed, each on its own address.
- R6: A read returns the most recent data for its address, including writes still pending. A write requested in the same cycle as the read, or in the cycle before, is merged byte by byte, newer over older.
- R7: After an edge with `rd_req_n` high, `q_valid` is 0 and both output words are 0 in the next cycle.
- R8: Data and enable inputs present in a cycle that follows no write request change no stored data.
- R9: Back-to-back writes to one address combine per byte, and the later write's enabled bytes win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_n | input | 1 | Read request, active low |
| wr_req_n | input | 1 | Write request, active low |
| a_rise | input | ADDR_W | Shared address bus, rising half: read address |
| a_fall | input | ADDR_W | Shared address bus, falling half: write address |
| d_first | input | BYTE_W*NBYTES | First write word, cycle after the write request |
| d_second | input | BYTE_W*NBYTES | Second write word, cycle after the write request |
| bw_first_n | input | NBYTES | Byte enables for the first word, active low |
| bw_second_n | input | NBYTES | Byte enables for the second word, active low |
| q_first | output | BYTE_W*NBYTES | First read word |
| q_second | output | BYTE_W*NBYTES | Second read word |
| q_valid | output | 1 | Read pair valid; low stands for a high-impedance bus |

## Verification
On every cycle the assertions check the read-valid timing after a request or an idle cycle, the zeroed outputs when no read is returned, and the array update at commit. For the update they check both a full-word write and a byte whose enable is high. They also check that a read hitting a same-cycle write with all bytes enabled returns the incoming words. The layered forwarding cases can only be shown by the bench's scenarios: a read that overlaps both pending stages with partial enables, back-to-back writes to one address, and data presented with no write behind it. The bench's per-cycle reference memory covers these.

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req_n,
  input  logic                       wr_req_n,
  input  logic [ADDR_W-1:0]          a_rise,
  input  logic [ADDR_W-1:0]          a_fall,
  input  logic [BYTE_W*NBYTES-1:0]   d_first,
  input  logic [BYTE_W*NBYTES-1:0]   d_second,
  input  logic [NBYTES-1:0]          bw_first_n,
  input  logic [NBYTES-1:0]          bw_second_n,
  output logic [BYTE_W*NBYTES-1:0]   q_first,
  output logic [BYTE_W*NBYTES-1:0]   q_second,
  output logic                       q_valid
);
  localparam int W     = BYTE_W * NBYTES;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem_a [DEPTH];
  logic [W-1:0] mem_b [DEPTH];

  logic              r1_v;
  logic [ADDR_W-1:0] r1_addr;
  logic              w1_v;
  logic [ADDR_W-1:0] w1_addr;
  logic              p_v;
  logic [ADDR_W-1:0] p_addr;
  logic [W-1:0]      p_d0, p_d1;
  logic [NBYTES-1:0] p_be0_n, p_be1_n;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_w,
                                         input logic [W-1:0] new_w,
                                         input logic [NBYTES-1:0] be_n);
    logic [W-1:0] r;
    for (int b = 0; b < NBYTES; b++)
      r[b*BYTE_W +: BYTE_W] = be_n[b] ? old_w[b*BYTE_W +: BYTE_W] : new_w[b*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic         hit_p, hit_w;
  logic [W-1:0] base0, base1, mid0, mid1, fwd0, fwd1;

  assign hit_p = p_v  && (p_addr  == r1_addr);
  assign hit_w = w1_v && (w1_addr == r1_addr);
  assign base0 = mem_a[r1_addr];
  assign base1 = mem_b[r1_addr];
  assign mid0  = hit_p ? merge(base0, p_d0, p_be0_n) : base0;
  assign mid1  = hit_p ? merge(base1, p_d1, p_be1_n) : base1;
  assign fwd0  = hit_w ? merge(mid0, d_first,  bw_first_n)  : mid0;
  assign fwd1  = hit_w ? merge(mid1, d_second, bw_second_n) : mid1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1_v     <= 1'b0;
      r1_addr  <= '0;
      w1_v     <= 1'b0;
      w1_addr  <= '0;
      p_v      <= 1'b0;
      p_addr   <= '0;
      p_d0     <= '0;
      p_d1     <= '0;
      p_be0_n  <= '1;
      p_be1_n  <= '1;
      q_valid  <= 1'b0;
      q_first  <= '0;
      q_second <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_a[i] <= '0;
        mem_b[i] <= '0;
      end
    end else begin
      r1_v    <= !rd_req_n;
      r1_addr <= a_rise;
      w1_v    <= !wr_req_n;
      w1_addr <= a_fall;
      p_v     <= w1_v;
      p_addr  <= w1_addr;
      p_d0    <= d_first;
      p_d1    <= d_second;
      p_be0_n <= bw_first_n;
      p_be1_n <= bw_second_n;
      if (p_v) begin
        mem_a[p_addr] <= merge(mem_a[p_addr], p_d0, p_be0_n);
        mem_b[p_addr] <= merge(mem_b[p_addr], p_d1, p_be1_n);
      end
      q_valid  <= r1_v;
      q_first  <= r1_v ? fwd0 : '0;
      q_second <= r1_v ? fwd1 : '0;
    end
  end

  // R2: a read request yields valid data one cycle after the next edge
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_n |=> r1_v |=> q_valid);

  // R7: no request, no valid data and a quiet bus
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !r1_v |=> (!q_valid && q_first == '0 && q_second == '0));

  // R3: a fully enabled commit stores both words
  a_r3_full_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (p_v && p_be0_n == '0 && p_be1_n == '0) |=>
      (mem_a[$past(p_addr)] == $past(p_d0) && mem_b[$past(p_addr)] == $past(p_d1)));

  // R4: a disabled low byte keeps its stored value
  a_r4_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (p_v && p_be0_n[0]) |=>
      mem_a[$past(p_addr)][BYTE_W-1:0] == $past(mem_a[p_addr][BYTE_W-1:0]));

  // R6: a same-cycle write with all bytes enabled is returned to the read
  a_r6_same_cycle_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (r1_v && w1_v && r1_addr == w1_addr && bw_first_n == '0 && bw_second_n == '0) |=>
      (q_first == $past(d_first) && q_second == $past(d_second)));
endmodule

// File: tb/test_qdr_b2_sram.sv
`timescale 1ns/1ps
module test_qdr_b2_sram;
  localparam int AW = 4;
  localparam int W  = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_req_n = 1'b1, wr_req_n = 1'b1;
  logic [AW-1:0] a_rise = '0, a_fall = '0;
  logic [W-1:0]  d_first = '0, d_second = '0;
  logic [1:0]    bw_first_n = 2'b11, bw_second_n = 2'b11;
  logic [W-1:0]  q_first, q_second;
  logic          q_valid;

  always #10 clk = ~clk;

  qdr_b2_sram #(.ADDR_W(AW), .BYTE_W(9), .NBYTES(2)) i_qdr_b2_sram (
    .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
    .a_rise(a_rise), .a_fall(a_fall), .d_first(d_first), .d_second(d_second),
    .bw_first_n(bw_first_n), .bw_second_n(bw_second_n),
    .q_first(q_first), .q_second(q_second), .q_valid(q_valid));

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  logic [W-1:0] ref0 [16];
  logic [W-1:0] ref1 [16];
  logic          prev_rd = 1'b0, prev_wr = 1'b0;
  logic [AW-1:0] prev_ra = '0, prev_wa = '0;
  logic          exp_v = 1'b0;
  logic [W-1:0]  exp0 = '0, exp1 = '0;

  function automatic logic [W-1:0] apply(input logic [W-1:0] o, input logic [W-1:0] n,
                                         input logic [1:0] be_n);
    logic [W-1:0] r = o;
    if (!be_n[0]) r[8:0]  = n[8:0];
    if (!be_n[1]) r[17:9] = n[17:9];
    return r;
  endfunction

  task automatic check_out();
    checks++;
    if (q_valid !== exp_v || q_first !== exp0 || q_second !== exp1) begin
      errors++;
      $display("FAIL %s: got v=%0b q0=%h q1=%h expected v=%0b q0=%h q1=%h",
               tag, q_valid, q_first, q_second, exp_v, exp0, exp1);
    end
  endtask

  task automatic cyc(input logic rd, input logic [AW-1:0] ra, input logic wr,
                     input logic [AW-1:0] wa, input logic [W-1:0] d0,
                     input logic [W-1:0] d1, input logic [1:0] b0, input logic [1:0] b1);
    @(negedge clk);
    check_out();
    rd_req_n = !rd; a_rise = ra; wr_req_n = !wr; a_fall = wa;
    d_first = d0; d_second = d1; bw_first_n = b0; bw_second_n = b1;
    if (prev_wr) begin
      ref0[prev_wa] = apply(ref0[prev_wa], d0, b0);
      ref1[prev_wa] = apply(ref1[prev_wa], d1, b1);
    end
    exp_v = prev_rd;
    exp0  = prev_rd ? ref0[prev_ra] : '0;
    exp1  = prev_rd ? ref1[prev_ra] : '0;
    prev_rd = rd; prev_ra = ra; prev_wr = wr; prev_wa = wa;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, '0, '0, 2'b11, 2'b11);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin ref0[i] = '0; ref1[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tag = "R1"; idle(2);
    for (int i = 0; i < 16; i++) cyc(1, i[AW-1:0], 0, '0, '0, '0, 2'b11, 2'b11);
    tag = "R7"; idle(3);

    tag = "R3";
    cyc(0, 0, 1, 3, '0, '0, 2'b11, 2'b11);
    cyc(0, 0, 0, 0, 18'h12345, 18'h2abcd, 2'b00, 2'b00);
    idle(3);
    cyc(1, 3, 0, 0, '0, '0, 2'b11, 2'b11);
    idle(2);

    tag = "R2";
    cyc(1, 3, 0, 0, '0, '0, 2'b11, 2'b11);
    cyc(1, 5, 0, 0, '0, '0, 2'b11, 2'b11);
    cyc(1, 3, 0, 0, '0, '0, 2'b11, 2'b11);
    idle(2);

    tag = "R4";
    cyc(0, 0, 1, 3, '0, '0, 2'b11, 2'b11);
    cyc(0, 0, 0, 0, 18'h3ffff, 18'h00000, 2'b01, 2'b10);
    idle(3);
    cyc(1, 3, 0, 0, '0, '0, 2'b11, 2'b11);
    idle(2);

    tag = "R8";
    cyc(0, 0, 0, 0, 18'h3ffff, 18'h3ffff, 2'b00, 2'b00);
    cyc(0, 0, 0, 0, 18'h15555, 18'h2aaaa, 2'b00, 2'b00);
    idle(3);
    cyc(1, 3, 0, 0, '0, '0, 2'b11, 2'b11);
    cyc(1, 0, 0, 0, '0, '0, 2'b11, 2'b11);
    idle(2);

    tag = "R5";
    cyc(1, 3, 1, 7, '0, '0, 2'b11, 2'b11);
    cyc(1, 7, 0, 0, 18'h0f0f0, 18'h30303, 2'b00, 2'b00);
    idle(3);

    tag = "R6";
    cyc(1, 9, 1, 9, '0, '0, 2'b11, 2'b11);
    cyc(1, 9, 1, 9, 18'h11111, 18'h22222, 2'b00, 2'b00);
    cyc(1, 9, 0, 0, 18'h33333, 18'h04444, 2'b10, 2'b01);
    cyc(1, 9, 0, 0, '0, '0, 2'b11, 2'b11);
    idle(3);

    tag = "R9";
    cyc(0, 0, 1, 12, '0, '0, 2'b11, 2'b11);
    cyc(0, 0, 1, 12, 18'h1aaaa, 18'h15555, 2'b00, 2'b00);
    cyc(1, 12, 0, 0, 18'h00001, 18'h3fffe, 2'b01, 2'b10);
    cyc(1, 12, 0, 0, '0, '0, 2'b11, 2'b11);
    idle(3);

    tag = "R6";
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1),
          $urandom_range(0, 3), W'($urandom), W'($urandom),
          2'($urandom), 2'($urandom));
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule